// File: doc/BRIEF.md
# Power Mode Supervisor for a Smart Load Switch

This block decides which operating mode a multi-channel smart load switch is in. It takes supply comparator flags that are already digital: battery above its power-on level, battery undervoltage, and logic supply above its rising or below its falling undervoltage level. It also takes decoded SPI command pulses, a load-current-increase flag, chip select, a limp-home pin, a watchdog failure flag with its enable, and a limp-home status bit. From these it moves between off, sleep, initialisation, self-test, active, low-power, battery-undervoltage and limp-home modes.

Waking from sleep always runs an initialisation phase and then a self-test phase before active is reached. Leaving low-power mode runs the self-test phase only. Each phase is timed by a counter whose length is a parameter. A failing self-test holds the block in that phase until the test passes.

The outputs are used by the channel drivers and the register file. They give the current mode as a one-hot vector, a gate for the channel outputs, a select that hands the channels to the limp-home or direct inputs, controls to keep or wipe the configuration registers, and a flag that says whether SPI traffic may be served.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is off. Asserting `allSupplyLost` forces off on the next clock edge from any mode. Off moves to sleep on the first edge where `batAbovePor` is 1.
- R2: `modeOneHot` always has exactly one bit set. The bit positions are off=0, sleep=1, init=2, self-test=3, active=4, low-power=5, battery-undervoltage=6, limp-home=7.
- R3: Sleep moves to init when `logicAboveRise` is 1 and either `csN` is 0 or `cmdWake` is 1. Otherwise sleep is held.
- R4: Init lasts exactly `INIT_CYC` cycles and then moves to self-test. Self-test lasts `BIST_CYC` cycles and then moves to active. While `bistFail` is 1 the block stays in self-test, and it reaches active on the first edge after `bistFail` returns to 0.
- R5: In active, `cmdSleep` moves to sleep and `cmdLpEnter` moves to low-power.
- R6: Low-power moves to self-test on `cmdLpExit` or `loadRise`. It then reaches active after `BIST_CYC` cycles, with no init phase.
- R7: Active moves to limp-home when `logicBelowFall` is 1, or `lhPin` is 1, or `wdFail` and `wdEnable` are both 1. `wdFail` alone has no effect.
- R8: Limp-home returns to active only when `logicAboveRise` is 1, `lhStatus` is 1 and `lhPin` is 0 all at once.
- R9: In limp-home, `outSrcLimp`=1, `outEnable`=1 and `regRetain`=1. `spiAllowed` follows `logicAboveRise`.
- R10: Active moves to battery-undervoltage when `batUnderVolt` is 1 and `logicAboveRise` is 1. It returns to active when `batUnderVolt` is 0. In battery-undervoltage, `outEnable`=0, `spiAllowed`=0 and `regRetain`=1.
- R11: When several exit causes are present in active at once, the priority is: supply loss, then battery undervoltage, then limp-home causes, then `cmdSleep`, then `cmdLpEnter`.
- R12: A command pulse that does not apply to the current mode leaves the mode unchanged. For example, a sleep command in low-power or in battery-undervoltage is ignored.
- R13: `outEnable`=1 only in active, low-power and limp-home. `regClear`=1 only in off, sleep and init. `regRetain`=1 in every other mode. `spiAllowed`=1 in active, and in limp-home while `logicAboveRise` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allSupplyLost | input | 1 | Power-on reset request after loss of all supplies |
| batAbovePor | input | 1 | Battery is above its power-on level |
| batUnderVolt | input | 1 | Battery is below its falling undervoltage level |
| logicAboveRise | input | 1 | Logic supply is above its rising undervoltage level |
| logicBelowFall | input | 1 | Logic supply is below its falling undervoltage level |
| csN | input | 1 | SPI chip select, active low |
| cmdSleep | input | 1 | Decoded sleep command pulse |
| cmdLpEnter | input | 1 | Decoded low-power entry command pulse |
| cmdLpExit | input | 1 | Decoded low-power exit command pulse |
| cmdWake | input | 1 | Decoded dummy wake frame pulse |
| loadRise | input | 1 | Load current increase seen in low-power |
| lhPin | input | 1 | Limp-home request pin |
| wdFail | input | 1 | SPI watchdog failure |
| wdEnable | input | 1 | SPI watchdog enabled |
| lhStatus | input | 1 | Limp-home release status bit |
| bistFail | input | 1 | Self-test has not yet passed |
| modeOneHot | output | 8 | Current mode, one-hot |
| outEnable | output | 1 | Channel outputs may be on |
| outSrcLimp | output | 1 | Channels driven from limp-home or direct inputs |
| regRetain | output | 1 | Configuration registers are kept |
| regClear | output | 1 | Configuration registers are wiped |
| spiAllowed | output | 1 | SPI transactions may be served |

## Verification
Several properties are checked on every cycle. The mode vector is always one-hot. Supply loss forces off one edge later. Active is only reached from self-test, battery-undervoltage or limp-home. A low-power exit always lands in self-test. Battery-undervoltage holds while the battery stays low. The phase counter stands still while a self-test is failing. Some behaviour can only be shown by the bench's scenarios. This covers the exact phase lengths, the priority order between simultaneous exit causes, and the rule that all three limp-home release conditions must hold together. It also covers ignored commands and the per-mode values of the gating, register and SPI outputs.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_INIT   = 3'd2,
    ST_BIST   = 3'd3,
    ST_ACTIVE = 3'd4,
    ST_LOWPWR = 3'd5,
    ST_BATUV  = 3'd6,
    ST_LIMP   = 3'd7
  } pmcState_e;

  localparam int NUM_MODES = 8;

  // strobes from the mode controller to the phase/decode datapath
  typedef struct packed {
    logic cntClr;     // mode changes this cycle: restart the phase counter
    logic cntRun;     // a timed phase is in progress
    logic phaseInit;  // 1: init phase, 0: self-test phase
  } pmcStrobe_t;

endpackage

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       allSupplyLost,
  input  logic       batAbovePor,
  input  logic       batUnderVolt,
  input  logic       logicAboveRise,
  input  logic       logicBelowFall,
  input  logic       csN,
  input  logic       cmdSleep,
  input  logic       cmdLpEnter,
  input  logic       cmdLpExit,
  input  logic       cmdWake,
  input  logic       loadRise,
  input  logic       lhPin,
  input  logic       wdFail,
  input  logic       wdEnable,
  input  logic       lhStatus,
  input  logic       initDone,
  input  logic       bistDone,
  output pmcState_e  state,
  output pmcStrobe_t strobe
);

  pmcState_e nextState;
  logic wakeReq, batUvEntry, limpCause, limpRelease, lpLeave;

  assign wakeReq     = logicAboveRise & (~csN | cmdWake);
  assign batUvEntry  = batUnderVolt & logicAboveRise;
  assign limpCause   = logicBelowFall | lhPin | (wdFail & wdEnable);
  assign limpRelease = logicAboveRise & lhStatus & ~lhPin;
  assign lpLeave     = cmdLpExit | loadRise;

  always_comb begin
    nextState = state;
    if (allSupplyLost) begin
      nextState = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:    if (batAbovePor) nextState = ST_SLEEP;
        ST_SLEEP:  if (wakeReq)     nextState = ST_INIT;
        ST_INIT:   if (initDone)    nextState = ST_BIST;
        ST_BIST:   if (bistDone)    nextState = ST_ACTIVE;
        ST_ACTIVE: begin
          if (batUvEntry)      nextState = ST_BATUV;
          else if (limpCause)  nextState = ST_LIMP;
          else if (cmdSleep)   nextState = ST_SLEEP;
          else if (cmdLpEnter) nextState = ST_LOWPWR;
        end
        ST_LOWPWR: if (lpLeave)       nextState = ST_BIST;
        ST_BATUV:  if (!batUnderVolt) nextState = ST_ACTIVE;
        ST_LIMP:   if (limpRelease)   nextState = ST_ACTIVE;
        default:   nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    strobe.cntClr    = (nextState != state);
    strobe.cntRun    = (state == ST_INIT) || (state == ST_BIST);
    strobe.phaseInit = (state == ST_INIT);
  end

  // R1: supply loss lands in off one edge later
  a_r1_por_forces_off: assert property (@(posedge clk) disable iff (!rstN)
    allSupplyLost |=> (state == ST_OFF));

  // R4: active is reached only from self-test, undervoltage or limp-home
  a_r4_active_entry_path: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ACTIVE) && ($past(state) != ST_ACTIVE)) |->
      (($past(state) == ST_BIST) || ($past(state) == ST_BATUV) || ($past(state) == ST_LIMP)));

  // R6: low-power exit goes through self-test
  a_r6_lowpwr_to_bist: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_LOWPWR) && !allSupplyLost && (cmdLpExit || loadRise)) |=> (state == ST_BIST));

  // R10: battery-undervoltage holds while the battery stays low
  a_r10_batuv_holds: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_BATUV) && !allSupplyLost && batUnderVolt) |=> (state == ST_BATUV));

endmodule

// File: rtl/pmc_dpath.sv
module pmc_dpath
  import pmc_pkg::*;
#(
  parameter int unsigned INIT_CYC = 16,
  parameter int unsigned BIST_CYC = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pmcState_e            state,
  input  pmcStrobe_t           strobe,
  input  logic                 bistFail,
  input  logic                 logicAboveRise,
  output logic                 initDone,
  output logic                 bistDone,
  output logic [NUM_MODES-1:0] modeOneHot,
  output logic                 outEnable,
  output logic                 outSrcLimp,
  output logic                 regRetain,
  output logic                 regClear,
  output logic                 spiAllowed
);

  localparam int unsigned CNT_MAX = (INIT_CYC > BIST_CYC) ? INIT_CYC : BIST_CYC;
  localparam int unsigned CW      = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CW-1:0] INIT_LIM = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] BIST_LIM = CW'(BIST_CYC - 1);

  logic [CW-1:0] phaseCnt;
  logic [CW-1:0] phaseLim;
  logic          atLimit;

  assign phaseLim = strobe.phaseInit ? INIT_LIM : BIST_LIM;
  assign atLimit  = (phaseCnt == phaseLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            phaseCnt <= '0;
    else if (strobe.cntClr)               phaseCnt <= '0;
    else if (strobe.cntRun && !atLimit)   phaseCnt <= phaseCnt + 1'b1;
  end

  assign initDone = strobe.cntRun &  strobe.phaseInit & atLimit;
  assign bistDone = strobe.cntRun & ~strobe.phaseInit & atLimit & ~bistFail;

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_mode
    assign modeOneHot[i] = (state == pmcState_e'(i));
  end

  assign outEnable  = modeOneHot[ST_ACTIVE] | modeOneHot[ST_LOWPWR] | modeOneHot[ST_LIMP];
  assign outSrcLimp = modeOneHot[ST_LIMP];
  assign regClear   = modeOneHot[ST_OFF] | modeOneHot[ST_SLEEP] | modeOneHot[ST_INIT];
  assign regRetain  = modeOneHot[ST_BIST] | modeOneHot[ST_ACTIVE] | modeOneHot[ST_LOWPWR]
                    | modeOneHot[ST_BATUV] | modeOneHot[ST_LIMP];
  assign spiAllowed = modeOneHot[ST_ACTIVE] | (modeOneHot[ST_LIMP] & logicAboveRise);

  // R2: exactly one mode at any time
  a_r2_mode_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(modeOneHot) == 1);

  // R4: a failing self-test at its last count keeps the counter still
  a_r4_bist_fail_holds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntRun && !strobe.phaseInit && atLimit && bistFail && !strobe.cntClr)
      |=> $stable(phaseCnt));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned INIT_CYC = 16,
  parameter int unsigned BIST_CYC = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       allSupplyLost,
  input  logic       batAbovePor,
  input  logic       batUnderVolt,
  input  logic       logicAboveRise,
  input  logic       logicBelowFall,
  input  logic       csN,
  input  logic       cmdSleep,
  input  logic       cmdLpEnter,
  input  logic       cmdLpExit,
  input  logic       cmdWake,
  input  logic       loadRise,
  input  logic       lhPin,
  input  logic       wdFail,
  input  logic       wdEnable,
  input  logic       lhStatus,
  input  logic       bistFail,
  output logic [7:0] modeOneHot,
  output logic       outEnable,
  output logic       outSrcLimp,
  output logic       regRetain,
  output logic       regClear,
  output logic       spiAllowed
);

  pmcState_e  state;
  pmcStrobe_t strobe;
  logic       initDone, bistDone;

  pmc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .allSupplyLost(allSupplyLost), .batAbovePor(batAbovePor),
    .batUnderVolt(batUnderVolt), .logicAboveRise(logicAboveRise),
    .logicBelowFall(logicBelowFall), .csN(csN),
    .cmdSleep(cmdSleep), .cmdLpEnter(cmdLpEnter), .cmdLpExit(cmdLpExit),
    .cmdWake(cmdWake), .loadRise(loadRise), .lhPin(lhPin),
    .wdFail(wdFail), .wdEnable(wdEnable), .lhStatus(lhStatus),
    .initDone(initDone), .bistDone(bistDone),
    .state(state), .strobe(strobe)
  );

  pmc_dpath #(.INIT_CYC(INIT_CYC), .BIST_CYC(BIST_CYC)) u_dpath (
    .clk(clk), .rstN(rstN), .state(state), .strobe(strobe),
    .bistFail(bistFail), .logicAboveRise(logicAboveRise),
    .initDone(initDone), .bistDone(bistDone),
    .modeOneHot(modeOneHot), .outEnable(outEnable), .outSrcLimp(outSrcLimp),
    .regRetain(regRetain), .regClear(regClear), .spiAllowed(spiAllowed)
  );

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;

  localparam int INIT_N = 4;
  localparam int BIST_N = 3;

  // stimulus bit positions
  localparam logic [15:0] M_BF   = 16'h8000, M_LOST = 16'h4000, M_BPOR = 16'h2000,
                          M_BUV  = 16'h1000, M_VR   = 16'h0800, M_VF   = 16'h0400,
                          M_CSN  = 16'h0200, M_SLP  = 16'h0100, M_LPE  = 16'h0080,
                          M_LPX  = 16'h0040, M_WAK  = 16'h0020, M_LOAD = 16'h0010,
                          M_LH   = 16'h0008, M_WDF  = 16'h0004, M_WDE  = 16'h0002,
                          M_LHS  = 16'h0001;
  localparam logic [15:0] NOM = M_BPOR | M_VR | M_CSN | M_LHS;

  localparam logic [7:0] OFF = 8'h01, SLP = 8'h02, INI = 8'h04, BST = 8'h08,
                         ACT = 8'h10, LPM = 8'h20, BUV = 8'h40, LMP = 8'h80;

  typedef struct packed {
    logic [15:0] stim;
    logic [7:0]  hold;
    logic [7:0]  mode;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [0:NV-1] = '{
    '{NOM,                          8'd1, SLP, 8'd1 },  // R1 off->sleep
    '{NOM,                          8'd3, SLP, 8'd3 },  // R3 cs high holds
    '{M_BPOR | M_LHS,               8'd2, SLP, 8'd3 },  // R3 cs low, logic low
    '{NOM & ~M_CSN,                 8'd1, INI, 8'd3 },  // R3 wake
    '{NOM,                          8'd3, INI, 8'd4 },  // R4 init length
    '{NOM,                          8'd1, BST, 8'd4 },
    '{NOM | M_BF,                   8'd5, BST, 8'd4 },  // R4 fail holds
    '{NOM,                          8'd1, ACT, 8'd4 },
    '{NOM | M_WAK | M_LPX | M_LOAD, 8'd2, ACT, 8'd12},  // R12 ignored
    '{NOM | M_WDF,                  8'd2, ACT, 8'd7 },  // R7 wd disabled
    '{NOM | M_WDF | M_WDE,          8'd1, LMP, 8'd7 },
    '{NOM & ~M_LHS,                 8'd2, LMP, 8'd8 },  // R8 status low
    '{NOM | M_LH,                   8'd1, LMP, 8'd8 },  // R8 pin high
    '{NOM & ~M_VR,                  8'd1, LMP, 8'd9 },  // R9 spi off
    '{NOM,                          8'd1, ACT, 8'd8 },
    '{NOM | M_LH,                   8'd1, LMP, 8'd7 },  // R7 pin
    '{NOM,                          8'd1, ACT, 8'd8 },
    '{(NOM & ~M_VR) | M_VF,         8'd1, LMP, 8'd7 },  // R7 logic fall
    '{NOM,                          8'd1, ACT, 8'd8 },
    '{NOM | M_LPE,                  8'd1, LPM, 8'd5 },  // R5
    '{NOM | M_SLP,                  8'd2, LPM, 8'd12},  // R12
    '{NOM | M_LOAD,                 8'd1, BST, 8'd6 },  // R6
    '{NOM,                          8'd2, BST, 8'd6 },
    '{NOM,                          8'd1, ACT, 8'd6 },
    '{NOM | M_LPE,                  8'd1, LPM, 8'd5 },
    '{NOM | M_LPX,                  8'd1, BST, 8'd6 },
    '{NOM,                          8'd3, ACT, 8'd6 },
    '{NOM | M_BUV,                  8'd1, BUV, 8'd10},  // R10
    '{NOM | M_BUV | M_SLP | M_LH,   8'd2, BUV, 8'd12},
    '{NOM,                          8'd1, ACT, 8'd10},
    '{NOM | M_BUV | M_LH | M_SLP | M_LPE, 8'd1, BUV, 8'd11}, // R11
    '{NOM,                          8'd1, ACT, 8'd10},
    '{NOM | M_LH | M_SLP | M_LPE,   8'd1, LMP, 8'd11},
    '{NOM,                          8'd1, ACT, 8'd8 },
    '{NOM | M_SLP | M_LPE,          8'd1, SLP, 8'd11},
    '{NOM | M_WAK,                  8'd1, INI, 8'd3 },  // R3 wake pulse
    '{NOM,                          8'd7, ACT, 8'd4 },
    '{(NOM & ~M_VR) | M_BUV,        8'd1, ACT, 8'd10},  // R10 needs logic up
    '{NOM | M_LOST,                 8'd1, OFF, 8'd1 },  // R1
    '{NOM & ~M_BPOR,                8'd2, OFF, 8'd1 }
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] stim = '0;
  logic [7:0] modeOneHot;
  logic outEnable, outSrcLimp, regRetain, regClear, spiAllowed;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.INIT_CYC(INIT_N), .BIST_CYC(BIST_N)) u_dut (
    .clk(clk), .rstN(rstN),
    .allSupplyLost(stim[14]), .batAbovePor(stim[13]), .batUnderVolt(stim[12]),
    .logicAboveRise(stim[11]), .logicBelowFall(stim[10]), .csN(stim[9]),
    .cmdSleep(stim[8]), .cmdLpEnter(stim[7]), .cmdLpExit(stim[6]),
    .cmdWake(stim[5]), .loadRise(stim[4]), .lhPin(stim[3]),
    .wdFail(stim[2]), .wdEnable(stim[1]), .lhStatus(stim[0]),
    .bistFail(stim[15]),
    .modeOneHot(modeOneHot), .outEnable(outEnable), .outSrcLimp(outSrcLimp),
    .regRetain(regRetain), .regClear(regClear), .spiAllowed(spiAllowed)
  );

  // expected {outEnable, outSrcLimp, regRetain, regClear, spiAllowed} per R9/R10/R13
  function automatic logic [4:0] expOuts(input logic [7:0] m, input logic vr);
    logic en, src, clr, spi;
    en  = (m == ACT) || (m == LPM) || (m == LMP);
    src = (m == LMP);
    clr = (m == OFF) || (m == SLP) || (m == INI);
    spi = (m == ACT) || ((m == LMP) && vr);
    return {en, src, ~clr, clr, spi};
  endfunction

  task automatic checkAll(input logic [7:0] expMode, input int req, input int idx);
    logic [4:0] got, exp;
    nChecks++;
    if (modeOneHot !== expMode) begin
      nFails++;
      $display("FAIL R%0d step %0d mode: actual %h expected %h", req, idx, modeOneHot, expMode);
    end
    nChecks++;
    got = {outEnable, outSrcLimp, regRetain, regClear, spiAllowed};
    exp = expOuts(expMode, stim[11]);
    if (got !== exp) begin
      nFails++;
      $display("FAIL R13 (R%0d) step %0d outputs: actual %b expected %b", req, idx, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // reset state, R1
    repeat (3) @(negedge clk);
    checkAll(OFF, 1, -1);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    checkAll(OFF, 1, -2);   // R1 no battery: stays off

    for (int i = 0; i < NV; i++) begin
      stim = VEC[i].stim;
      repeat (int'(VEC[i].hold)) @(posedge clk);
      @(negedge clk);
      checkAll(VEC[i].mode, int'(VEC[i].req), i);
    end

    // R1 supply loss from init
    stim = NOM;
    @(posedge clk); @(negedge clk);
    checkAll(SLP, 1, 100);
    stim = NOM & ~M_CSN;
    @(posedge clk); @(negedge clk);
    checkAll(INI, 3, 101);
    stim = NOM | M_LOST;
    @(posedge clk); @(negedge clk);
    checkAll(OFF, 1, 102);

    // R1 asynchronous reset from sleep
    stim = NOM;
    @(posedge clk); @(negedge clk);
    checkAll(SLP, 1, 103);
    rstN = 1'b0;
    #1;
    checkAll(OFF, 1, 104);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    checkAll(SLP, 1, 105);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule